// File: doc/BRIEF.md
# CAN Receive Mailbox Dispatcher

This block sits behind a CAN receive engine that has already turned bus bits into whole frames. Each accepted frame is presented for one clock with its 11-bit identifier, a 4-bit length code and 64 bits of payload. The dispatcher picks at most one of four mailboxes to store the frame in and raises that mailbox's interrupt flag according to the mailbox's mode. A CPU reads the stored frames through a small read port and clears flags by writing ones to a mask.

Each mailbox is set up with an enable bit, a mode and an identifier. The modes can be mixed in one controller. A catch-all mailbox takes any frame that no dedicated mailbox claims. A single-message mailbox owns one identifier and flags every match. A batching mailbox owns one identifier, queues up to four frames and flags once per fourth accepted frame. This lets urgent traffic interrupt on every frame while periodic traffic, such as sensor readings, interrupts only once per batch.

Top module: `can_rx_mailbox_hub`

## Requirements
- R1: After a clock edge with `rst_n` low, every mailbox is disabled and `irq_flag`, `ovr_flag` and `rd_avail` (for every `rd_sel`) read 0.
- R2: A configuration write (`cfg_we`, `cfg_sel`) loads enable, mode and identifier for one mailbox and empties it: stored frames, flag, overrun bit and batch count all return to zero. Mode code 2'b00 is catch-all, 2'b01 single-message, 2'b10 batching, and 2'b11 is reserved. A disabled mailbox and a mailbox in mode 2'b11 receive nothing.
- R3: A frame whose identifier equals that of an enabled single-message mailbox is stored there. The mailbox's bit in `irq_flag` is 1 one clock after `frm_valid`, on every match.
- R4: When a single-message or catch-all mailbox receives a frame while its flag is still set, the new frame replaces the stored one and its `ovr_flag` bit becomes 1 and stays 1 until the next configuration write to it.
- R5: A batching mailbox keeps up to four frames in arrival order. The read port shows the oldest one, and `rd_pop` with `rd_sel` pointing at it removes exactly one entry per strobe. `rd_avail` is 0 when the queue is empty.
- R6: A batching mailbox sets its flag on the 4th, 8th, 12th, ... frame it accepts, and never on the others.
- R7: A frame that matches a batching mailbox already holding four unread frames is discarded. The queue contents are unchanged and the `ovr_flag` bit becomes 1.
- R8: Dedicated mailboxes (single-message and batching) are matched first. A frame that matches none of them goes to the lowest-numbered enabled catch-all mailbox, which stores it, flags it and overruns as in R3 and R4.
- R9: A frame that matches no dedicated identifier, when no catch-all mailbox is enabled, is dropped and changes no flag, overrun bit or stored frame.
- R10: When several enabled dedicated mailboxes share an identifier, only the lowest-numbered one receives the frame.
- R11: With `clr_we` high, each 1 in `clr_mask` clears the matching `irq_flag` bit at the next edge, and each 0 leaves it alone. A flag set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Mailbox addressed by the configuration write |
| cfg_en | input | 1 | Enable bit written to the mailbox |
| cfg_mode | input | 2 | Mode code: 00 catch-all, 01 single-message, 10 batching, 11 reserved |
| cfg_id | input | 11 | Identifier written to the mailbox |
| frm_valid | input | 1 | One-cycle pulse: a received frame is present |
| frm_id | input | 11 | Identifier of the received frame |
| frm_dlc | input | 4 | Length code of the received frame |
| frm_data | input | 64 | Payload of the received frame |
| rd_sel | input | 2 | Mailbox shown on the read port |
| rd_pop | input | 1 | Removes the head entry of the selected batching mailbox |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 4 | Write-one-to-clear mask for `irq_flag` |
| rd_avail | output | 1 | Selected mailbox holds a readable frame |
| rd_id | output | 11 | Identifier of the frame shown |
| rd_dlc | output | 4 | Length code of the frame shown |
| rd_data | output | 64 | Payload of the frame shown |
| irq_flag | output | 4 | Per-mailbox interrupt flags |
| ovr_flag | output | 4 | Per-mailbox sticky overrun bits |

## Verification
Directed bursts on one identifier show apart the per-frame flagging of single-message mailboxes and the once-per-four flagging of batching ones. A fifth unread frame and repeated frames before a clear expose the discard-on-overflow and overwrite-on-overrun policies. Frames with unclaimed identifiers, with and without a catch-all mailbox, and identifiers shared by two dedicated mailboxes separate the fallback path, the drop path and lowest-index priority. A long random mix of identifiers, pops, clears and reconfigurations across all modes is compared cycle by cycle against a bench model, which catches ordering, pointer and same-cycle interaction faults.

// File: rtl/can_mbx_pkg.sv
// Shared types for the receive mailbox dispatcher.
// Assumes 11-bit identifiers and payloads of at most 8 bytes.
package can_mbx_pkg;

    localparam int ID_W   = 11;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;

    // Mailbox mode codes as written through the configuration port.
    typedef enum logic [1:0] {
        MB_BASIC = 2'b00,
        MB_FULL  = 2'b01,
        MB_EXT   = 2'b10,
        MB_OFF   = 2'b11
    } mb_mode_e;

    // One stored frame.
    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } can_frame_t;

endpackage

// File: rtl/can_mbx_route.sv
// Chooses the single destination mailbox for an incoming frame.
// Dedicated mailboxes (single-message and batching) with a matching
// identifier win over catch-all mailboxes, and the lowest index wins
// inside each group. Assumes the configuration inputs are registered.
module can_mbx_route #(
    parameter int NUM_BOX = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  frm_valid,
    input  logic [can_mbx_pkg::ID_W-1:0]          frm_id,
    input  logic [NUM_BOX-1:0]                    box_en,
    input  logic [NUM_BOX-1:0][1:0]               box_mode,
    input  logic [NUM_BOX-1:0][can_mbx_pkg::ID_W-1:0] box_id,
    output logic [NUM_BOX-1:0]                    grant
);
    import can_mbx_pkg::*;

    logic [NUM_BOX-1:0] ded_hit;
    logic [NUM_BOX-1:0] base_ok;

    // Keep only the lowest set bit of a vector.
    function automatic logic [NUM_BOX-1:0] lowest(input logic [NUM_BOX-1:0] v);
        return v & (~v + NUM_BOX'(1));
    endfunction

    // Classify every mailbox as a dedicated hit or a catch-all candidate.
    always_comb begin
        for (int i = 0; i < NUM_BOX; i++) begin
            ded_hit[i] = box_en[i] &&
                         (box_mode[i] == MB_FULL || box_mode[i] == MB_EXT) &&
                         (box_id[i] == frm_id);
            base_ok[i] = box_en[i] && (box_mode[i] == MB_BASIC);
        end
    end

    // Dedicated match first, catch-all as fallback, nothing otherwise.
    always_comb begin
        if (!frm_valid)
            grant = '0;
        else if (|ded_hit)
            grant = lowest(ded_hit);
        else
            grant = lowest(base_ok);
    end

    // R10: at most one mailbox receives any frame.
    assert_single_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9: no frame, no delivery.
    assert_idle_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |-> (grant == '0));

    // R8: a catch-all mailbox is never chosen while a dedicated one matches.
    assert_dedicated_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && (|ded_hit)) |-> ((grant & ded_hit) == grant && grant != '0));

endmodule

// File: rtl/can_mbx_box.sv
// One receive mailbox. In batching mode it is a queue of DEPTH frames
// that flags once per BATCH accepted frames and discards frames when
// full. In the other modes only slot 0 is used: each frame overwrites it,
// flags, and marks overrun if the flag was still set.
// Assumes DEPTH >= 2 and that the mode changes only together with wipe.
module can_mbx_box #(
    parameter int DEPTH = 4,
    parameter int BATCH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wipe,
    input  logic [1:0]              mode,
    input  logic                    push,
    input  can_mbx_pkg::can_frame_t frame_in,
    input  logic                    pop,
    input  logic                    flag_clr,
    output can_mbx_pkg::can_frame_t head,
    output logic                    avail,
    output logic                    flag,
    output logic                    ovr
);
    import can_mbx_pkg::*;

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int BW = (BATCH > 1) ? $clog2(BATCH) : 1;

    can_frame_t     mem [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  cnt;
    logic [BW-1:0]  batch;
    logic           hold;

    logic           is_ext;
    logic           acc;
    logic           acc_ext;
    logic           pop_ok;
    logic           batch_hit;
    logic           flag_set;
    logic [PW-1:0]  wr_idx;

    // Decode this cycle's accept, pop and flag events.
    always_comb begin
        is_ext    = (mode == MB_EXT);
        acc       = is_ext ? (push && cnt != CW'(DEPTH)) : push;
        acc_ext   = acc && is_ext;
        pop_ok    = is_ext && pop && (cnt != '0);
        batch_hit = (batch == BW'(BATCH - 1));
        flag_set  = is_ext ? (acc && batch_hit) : push;
        wr_idx    = is_ext ? wr_ptr : '0;
    end

    // Frame storage; contents are only meaningful while avail is high.
    always_ff @(posedge clk) begin
        if (acc)
            mem[wr_idx] <= frame_in;
    end

    // Pointers, occupancy, batch count, flag and overrun state.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            batch  <= '0;
            hold   <= 1'b0;
            flag   <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if (acc_ext)
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            if (pop_ok)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            cnt <= cnt + CW'(acc_ext) - CW'(pop_ok);
            if (acc_ext)
                batch <= batch_hit ? '0 : batch + BW'(1);
            if (push && !is_ext)
                hold <= 1'b1;
            flag <= flag_set | (flag & ~flag_clr);
            if (is_ext ? (push && !acc) : (push && flag))
                ovr <= 1'b1;
        end
    end

    // Present the oldest entry in batching mode, slot 0 otherwise.
    always_comb begin
        head  = is_ext ? mem[rd_ptr] : mem[0];
        avail = is_ext ? (cnt != '0) : hold;
    end

    // R5: occupancy never exceeds the queue depth.
    assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R7: a frame arriving at a full queue marks overrun.
    assert_full_drop_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && is_ext && push && cnt == CW'(DEPTH)) |=> ovr);

    // R7: a discarded frame does not change occupancy.
    assert_full_drop_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && is_ext && push && !pop && cnt == CW'(DEPTH)) |=> (cnt == CW'(DEPTH)));

    // R3: every delivery to a single-slot mailbox raises its flag.
    assert_single_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && !is_ext && push) |=> flag);

    // R4: delivery while flagged leaves the overrun bit set.
    assert_overwrite_ovr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && !is_ext && push && flag) |=> ovr);

    // R11: a clear with no new delivery drops the flag.
    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !push) |=> !flag);

    // R4: the overrun bit is sticky until a wipe.
    assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !wipe) |=> ovr);

endmodule

// File: rtl/can_rx_mailbox_hub.sv
// Receive mailbox dispatcher: holds per-mailbox configuration, routes
// each decoded frame to one mailbox and exposes a read and clear port.
// Assumes NUM_BOX is a power of two so every rd_sel value is a mailbox,
// and that frm_valid is a single-cycle pulse per frame.
module can_rx_mailbox_hub #(
    parameter int NUM_BOX    = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int IRQ_BATCH  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [$clog2(NUM_BOX)-1:0]        cfg_sel,
    input  logic                              cfg_en,
    input  logic [1:0]                        cfg_mode,
    input  logic [can_mbx_pkg::ID_W-1:0]      cfg_id,
    input  logic                              frm_valid,
    input  logic [can_mbx_pkg::ID_W-1:0]      frm_id,
    input  logic [can_mbx_pkg::DLC_W-1:0]     frm_dlc,
    input  logic [can_mbx_pkg::DATA_W-1:0]    frm_data,
    input  logic [$clog2(NUM_BOX)-1:0]        rd_sel,
    input  logic                              rd_pop,
    input  logic                              clr_we,
    input  logic [NUM_BOX-1:0]                clr_mask,
    output logic                              rd_avail,
    output logic [can_mbx_pkg::ID_W-1:0]      rd_id,
    output logic [can_mbx_pkg::DLC_W-1:0]     rd_dlc,
    output logic [can_mbx_pkg::DATA_W-1:0]    rd_data,
    output logic [NUM_BOX-1:0]                irq_flag,
    output logic [NUM_BOX-1:0]                ovr_flag
);
    import can_mbx_pkg::*;

    localparam int SEL_W = $clog2(NUM_BOX);

    logic [NUM_BOX-1:0]           en_q;
    logic [NUM_BOX-1:0][1:0]      mode_q;
    logic [NUM_BOX-1:0][ID_W-1:0] id_q;
    logic [NUM_BOX-1:0]           grant;
    logic [NUM_BOX-1:0]           box_avail;
    can_frame_t                   heads [NUM_BOX];
    can_frame_t                   frm_in;

    // Configuration registers, one set per mailbox.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
            id_q   <= '0;
        end else if (cfg_we) begin
            en_q[cfg_sel]   <= cfg_en;
            mode_q[cfg_sel] <= cfg_mode;
            id_q[cfg_sel]   <= cfg_id;
        end
    end

    // Pack the incoming frame fields.
    always_comb begin
        frm_in.id   = frm_id;
        frm_in.dlc  = frm_dlc;
        frm_in.data = frm_data;
    end

    can_mbx_route #(
        .NUM_BOX (NUM_BOX)
    ) route_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm_id    (frm_id),
        .box_en    (en_q),
        .box_mode  (mode_q),
        .box_id    (id_q),
        .grant     (grant)
    );

    for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
        logic wipe_i;
        logic pop_i;
        logic clr_i;

        // Per-mailbox strobes decoded from the shared ports.
        always_comb begin
            wipe_i = cfg_we && (cfg_sel == SEL_W'(i));
            pop_i  = rd_pop && (rd_sel == SEL_W'(i));
            clr_i  = clr_we && clr_mask[i];
        end

        can_mbx_box #(
            .DEPTH (FIFO_DEPTH),
            .BATCH (IRQ_BATCH)
        ) box_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wipe     (wipe_i),
            .mode     (mode_q[i]),
            .push     (grant[i]),
            .frame_in (frm_in),
            .pop      (pop_i),
            .flag_clr (clr_i),
            .head     (heads[i]),
            .avail    (box_avail[i]),
            .flag     (irq_flag[i]),
            .ovr      (ovr_flag[i])
        );
    end

    // Read port multiplexer.
    always_comb begin
        rd_avail = box_avail[rd_sel];
        rd_id    = heads[rd_sel].id;
        rd_dlc   = heads[rd_sel].dlc;
        rd_data  = heads[rd_sel].data;
    end

    // R2: a configuration write leaves the addressed mailbox empty and quiet.
    assert_cfg_wipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!irq_flag[$past(cfg_sel)] && !ovr_flag[$past(cfg_sel)] &&
                    !box_avail[$past(cfg_sel)]));

endmodule

// File: tb/can_rx_mailbox_hub_tb_top.sv
`timescale 1ns/1ps
module can_rx_mailbox_hub_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_en, frm_valid, rd_pop, clr_we;
    logic [1:0]  cfg_sel, cfg_mode, rd_sel;
    logic [10:0] cfg_id, frm_id;
    logic [3:0]  frm_dlc, clr_mask;
    logic [63:0] frm_data;
    logic        rd_avail;
    logic [10:0] rd_id;
    logic [3:0]  rd_dlc;
    logic [63:0] rd_data;
    logic [3:0]  irq_flag, ovr_flag;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    can_rx_mailbox_hub dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
        .cfg_mode(cfg_mode), .cfg_id(cfg_id),
        .frm_valid(frm_valid), .frm_id(frm_id), .frm_dlc(frm_dlc), .frm_data(frm_data),
        .rd_sel(rd_sel), .rd_pop(rd_pop), .clr_we(clr_we), .clr_mask(clr_mask),
        .rd_avail(rd_avail), .rd_id(rd_id), .rd_dlc(rd_dlc), .rd_data(rd_data),
        .irq_flag(irq_flag), .ovr_flag(ovr_flag)
    );

    // ---------------- reference model ----------------
    logic        m_en   [4];
    logic [1:0]  m_mode [4];
    logic [10:0] m_idr  [4];
    logic [78:0] m_q    [4][4];
    int          m_cnt  [4];
    int          m_bat  [4];
    logic        m_flag [4];
    logic        m_ovr  [4];
    logic        m_hold [4];

    function automatic int route(input logic [10:0] id);
        for (int b = 0; b < 4; b++)
            if (m_en[b] && (m_mode[b] == 2'b01 || m_mode[b] == 2'b10) && m_idr[b] == id)
                return b;
        for (int b = 0; b < 4; b++)
            if (m_en[b] && m_mode[b] == 2'b00)
                return b;
        return -1;
    endfunction

    function automatic logic m_avail(input int b);
        return (m_mode[b] == 2'b10) ? (m_cnt[b] != 0) : m_hold[b];
    endfunction

    function automatic logic [3:0] m_flags();
        logic [3:0] v;
        for (int b = 0; b < 4; b++) v[b] = m_flag[b];
        return v;
    endfunction

    function automatic logic [3:0] m_ovrs();
        logic [3:0] v;
        for (int b = 0; b < 4; b++) v[b] = m_ovr[b];
        return v;
    endfunction

    task automatic model_wipe(input int b);
        m_cnt[b] = 0; m_bat[b] = 0; m_flag[b] = 0; m_ovr[b] = 0; m_hold[b] = 0;
    endtask

    // Apply the effect of the coming clock edge to the model.
    task automatic model_edge();
        int g;
        logic [78:0] f;
        g = (rst_n && frm_valid) ? route(frm_id) : -1;
        f = {frm_id, frm_dlc, frm_data};
        for (int b = 0; b < 4; b++) begin
            logic psh, pp, cl, acc;
            psh = (g == b);
            pp  = rd_pop && (rd_sel == 2'(b));
            cl  = clr_we && clr_mask[b];
            if (!rst_n) begin
                model_wipe(b); m_en[b] = 0; m_mode[b] = 0; m_idr[b] = 0;
            end else if (cfg_we && cfg_sel == 2'(b)) begin
                model_wipe(b); m_en[b] = cfg_en; m_mode[b] = cfg_mode; m_idr[b] = cfg_id;
            end else if (m_mode[b] == 2'b10) begin
                logic set;
                acc = psh && (m_cnt[b] != 4);
                if (psh && !acc) m_ovr[b] = 1;
                set = acc && (m_bat[b] == 3);
                if (acc) m_bat[b] = (m_bat[b] + 1) % 4;
                if (pp && m_cnt[b] != 0) begin
                    for (int k = 0; k < 3; k++) m_q[b][k] = m_q[b][k+1];
                    m_cnt[b]--;
                end
                if (acc) begin m_q[b][m_cnt[b]] = f; m_cnt[b]++; end
                m_flag[b] = set | (m_flag[b] & !cl);
            end else begin
                if (psh) begin
                    if (m_flag[b]) m_ovr[b] = 1;
                    m_q[b][0] = f; m_hold[b] = 1;
                end
                m_flag[b] = psh | (m_flag[b] & !cl);
            end
        end
    endtask

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            chk(tag, $sformatf("avail[%0d]", s), 128'(rd_avail), 128'(m_avail(s)));
            if (m_avail(s))
                chk(tag, $sformatf("frame[%0d]", s), 128'({rd_id, rd_dlc, rd_data}), 128'(m_q[s][0]));
        end
        chk(tag, "irq_flag", 128'(irq_flag), 128'(m_flags()));
        chk(tag, "ovr_flag", 128'(ovr_flag), 128'(m_ovrs()));
    endtask

    task automatic tick();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0; frm_valid = 0; rd_pop = 0; clr_we = 0;
    endtask

    task automatic cfg(input int b, input logic en, input logic [1:0] md, input logic [10:0] id);
        cfg_we = 1; cfg_sel = 2'(b); cfg_en = en; cfg_mode = md; cfg_id = id;
        tick();
    endtask

    task automatic send(input logic [10:0] id, input logic [63:0] d);
        frm_valid = 1; frm_id = id; frm_dlc = 4'd8; frm_data = d;
        tick();
    endtask

    task automatic pop_box(input int b);
        rd_sel = 2'(b); rd_pop = 1;
        tick();
    endtask

    task automatic clear(input logic [3:0] m);
        clr_we = 1; clr_mask = m;
        tick();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #3000000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_en = 0; cfg_mode = 0; cfg_id = 0;
        frm_valid = 0; frm_id = 0; frm_dlc = 0; frm_data = 0;
        rd_sel = 0; rd_pop = 0; clr_we = 0; clr_mask = 0;
        @(negedge clk);
        tick(); tick();
        rst_n = 1;
        // R1: reset state.
        chk("R1", "irq_flag", 128'(irq_flag), 128'(0));
        chk("R1", "ovr_flag", 128'(ovr_flag), 128'(0));
        compare_all("R1");

        // R2: mixed modes; box3 shares 0x250 with box0.
        cfg(0, 1, 2'b01, 11'h250);
        cfg(1, 1, 2'b10, 11'h3FF);
        cfg(2, 1, 2'b00, 11'h000);
        cfg(3, 1, 2'b01, 11'h250);
        compare_all("R2");

        // R3 / R10: single-message match, lowest index wins.
        send(11'h250, 64'hA0A0);
        chk("R3", "irq_flag", 128'(irq_flag), 128'(4'b0001));
        rd_sel = 3; #1;
        chk("R10", "box3 avail", 128'(rd_avail), 128'(0));
        compare_all("R10");

        // R4: overwrite while flagged.
        send(11'h250, 64'hB0B0);
        rd_sel = 0; #1;
        chk("R4", "data", 128'(rd_data), 128'(64'hB0B0));
        chk("R4", "ovr_flag", 128'(ovr_flag), 128'(4'b0001));
        compare_all("R4");

        // R6: batching flag only on the fourth frame.
        for (int k = 0; k < 4; k++) begin
            send(11'h3FF, 64'hD0 + 64'(k));
            chk("R6", "irq bit1", 128'(irq_flag[1]), 128'(k == 3));
            compare_all("R6");
        end

        // R7: fifth unread frame is discarded.
        send(11'h3FF, 64'hEE);
        chk("R7", "ovr bit1", 128'(ovr_flag[1]), 128'(1));
        compare_all("R7");

        // R5: oldest first, one entry per pop.
        for (int k = 0; k < 4; k++) begin
            rd_sel = 1; #1;
            chk("R5", "head data", 128'(rd_data), 128'(64'hD0 + 64'(k)));
            pop_box(1);
        end
        rd_sel = 1; #1;
        chk("R5", "empty", 128'(rd_avail), 128'(0));
        compare_all("R5");

        // R8: unclaimed identifier falls to the catch-all mailbox.
        send(11'h123, 64'h1234);
        chk("R8", "irq bit2", 128'(irq_flag[2]), 128'(1));
        compare_all("R8");

        // R11: write-one-to-clear with a partial mask.
        clear(4'b0101);
        chk("R11", "irq_flag", 128'(irq_flag), 128'(4'b0010));
        compare_all("R11");

        // R11: clear and set in the same cycle keeps the flag.
        clr_we = 1; clr_mask = 4'b0001;
        send(11'h250, 64'hC1);
        chk("R11", "set wins", 128'(irq_flag[0]), 128'(1));
        compare_all("R11");

        // R2: disabling wipes the mailbox; R9: no catch-all means drop.
        cfg(2, 0, 2'b00, 11'h000);
        rd_sel = 2; #1;
        chk("R2", "wiped", 128'(rd_avail), 128'(0));
        send(11'h123, 64'h55);
        chk("R9", "irq_flag", 128'(irq_flag), 128'(m_flags()));
        compare_all("R9");

        // R2: reserved mode receives nothing.
        cfg(2, 1, 2'b11, 11'h123);
        send(11'h123, 64'h66);
        rd_sel = 2; #1;
        chk("R2", "reserved", 128'({rd_avail, irq_flag[2]}), 128'(0));
        compare_all("R2");

        // Random mix across all modes against the model.
        for (int n = 0; n < 4000; n++) begin
            if (n % 250 == 0) begin
                int r;
                r = int'($urandom % 4);
                case ($urandom % 4)
                    0: cfg(r, 1, 2'($urandom % 4), 11'h250);
                    1: cfg(r, 1, 2'($urandom % 4), 11'h3FF);
                    2: cfg(r, 1'($urandom), 2'b00, 11'h0);
                    default: cfg(r, 1, 2'b10, 11'h123);
                endcase
                compare_all("R2");
            end
            if ($urandom % 10 < 7) begin
                frm_valid = 1;
                case ($urandom % 4)
                    0: frm_id = 11'h250;
                    1: frm_id = 11'h3FF;
                    2: frm_id = 11'h123;
                    default: frm_id = 11'($urandom);
                endcase
                frm_dlc = 4'($urandom % 9);
                frm_data = {$urandom, $urandom};
            end
            rd_sel = 2'($urandom);
            rd_pop = ($urandom % 3 == 0);
            clr_we = ($urandom % 4 == 0);
            clr_mask = 4'($urandom);
            tick();
            compare_all("R8 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule